// File: doc/BRIEF.md
# Interrupt Aggregation Slave

This block is a register slave on a Wishbone bus. It collects interrupt request pulses from up to sixteen peripheral blocks and turns them into a single interrupt line for the host processor. Each request line has its own pending flag. A request pulse sets the flag, and the flag stays set until software clears it. A mask register chooses which pending flags are allowed to drive the host line. A masked source still records its request, so software can still see it.

Software takes the host interrupt and reads the pending register to find which sources are waiting. It then clears each one it has handled by writing a 1 to that bit. Bits written as 0 are left as they are, so one write can acknowledge exactly the sources that were handled. If a fresh request arrives in the same cycle as a clear of the same bit, the request wins, so no event is lost.

Top module: `irq_gather`

## Requirements
- R1: While reset is high and after it is released, every pending bit and every mask bit reads 0, `host_irq_o` is low and `wb_ack_o` is low.
- R2: A source input that is 1 at a rising clock edge sets its pending bit, and the bit reads 1 from the next cycle on.
- R3: A pending bit never goes from 0 to 1 unless its source input was 1 at the previous edge, and a set bit stays set until it is cleared.
- R4: A bus write to word offset 0 (pending) clears every pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R5: If a source input is 1 in the same cycle that a write to offset 0 clears its bit, the bit stays set.
- R6: Word offset 1 (mask) is readable and writable. Bit i enables source i onto the host line. A write there does not change any pending bit.
- R7: `host_irq_o` is 1 exactly when some bit i has both pending and mask set. A masked source still latches its pending bit.
- R8: An access cycle (cyc and stb high, ack low) is answered by `wb_ack_o` high for exactly one cycle at the next edge. Read data is valid while ack is high and shows register state from before that edge.
- R9: Reads of offsets 2 and 3 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Word offset |
| wb_dat_i | input | 16 | Write data |
| wb_dat_o | output | 16 | Read data, valid with ack |
| wb_ack_o | output | 1 | Access acknowledge |
| irq_src_i | input | N_SRC | Request pulses, one per source |
| host_irq_o | output | 1 | Aggregated processor interrupt |

## Verification
The case that matters most is a source pulse arriving in the same clock edge as a software write that clears that source's pending bit. The bench forces this case on purpose. It drives a request on a bit at the exact edge where a clear of that bit is accepted, then reads the register back and expects the bit still set. Random traffic also lets request pulses and clear writes overlap on many bits at once. A behavioural model checks the pending state, the host line and the read data against the design on every cycle.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int N_SRC  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [15:0]       wb_dat_i,
  output logic [15:0]       wb_dat_o,
  output logic              wb_ack_o,
  input  logic [N_SRC-1:0]  irq_src_i,
  output logic              host_irq_o
);

  localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(1);

  logic [N_SRC-1:0] pend_q, mask_q, clr;
  logic [15:0]      rmux;
  logic             access, wr;

  assign access = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign wr     = access & wb_we_i;
  assign clr    = (wr && wb_adr_i == OFF_PEND) ? wb_dat_i[N_SRC-1:0] : '0;

  always_comb begin
    rmux = '0;
    if (wb_adr_i == OFF_PEND)      rmux[N_SRC-1:0] = pend_q;
    else if (wb_adr_i == OFF_MASK) rmux[N_SRC-1:0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      mask_q   <= '0;
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      pend_q   <= (pend_q & ~clr) | irq_src_i;
      wb_ack_o <= access;
      if (access && !wb_we_i) wb_dat_o <= rmux;
      if (wr && wb_adr_i == OFF_MASK) mask_q <= wb_dat_i[N_SRC-1:0];
    end
  end

  assign host_irq_o = |(pend_q & mask_q);

  a_r2_latch: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(irq_src_i)) == $past(irq_src_i)));

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(irq_src_i)) == '0));

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(clr & ~irq_src_i)) == '0));

  a_r8_ack_follows: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

  a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);

  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !host_irq_o);

endmodule

// File: tb/irq_gather_tb.sv
module irq_gather_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 0, rst = 1;
  logic cyc = 0, stb = 0, we = 0;
  logic [1:0] adr = 0;
  logic [15:0] dat_w = 0;
  logic [15:0] dat_r;
  logic ack, hirq;
  logic [N-1:0] src = 0;

  int n_run = 0, n_fail = 0;

  logic [N-1:0] pend_m = 0, mask_m = 0;
  logic ack_m = 0, rd_m = 0;
  logic [15:0] dat_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gather #(.N_SRC(N), .ADDR_W(2)) u_dut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat_w), .wb_dat_o(dat_r), .wb_ack_o(ack),
    .irq_src_i(src), .host_irq_o(hirq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic hit;
    if (rst) begin
      pend_m = 0; mask_m = 0; ack_m = 0; rd_m = 0;
    end else begin
      hit = cyc && stb && !ack_m;
      if (hit && !we) dat_m = (adr == 0) ? pend_m : (adr == 1) ? mask_m : 16'h0;
      rd_m = hit && !we;
      ack_m = hit;
      if (hit && we && adr == 0) pend_m = pend_m & ~dat_w;
      if (hit && we && adr == 1) mask_m = dat_w;
      pend_m = pend_m | src;
    end
  end

  always @(negedge clk) begin
    check(hirq == |(pend_m & mask_m), "R7", hirq, |(pend_m & mask_m));
    check(ack == ack_m, "R8", ack, ack_m);
    if (ack_m && rd_m) check(dat_r == dat_m, "R9 read data", dat_r, dat_m);
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; dat_w = d;
    @(negedge clk); cyc = 0; stb = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk); d = dat_r; cyc = 0; stb = 0;
  endtask

  task automatic pulse(input logic [N-1:0] s);
    @(negedge clk); src = s;
    @(negedge clk); src = 0;
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    check(hirq == 0 && ack == 0, "R1 in reset", {hirq, ack}, 0);
    rst = 0;
    bus_rd(0, v); check(v == 0, "R1 pending", v, 0);
    bus_rd(1, v); check(v == 0, "R1 mask", v, 0);

    pulse(16'h0005);
    bus_rd(0, v); check(v == 16'h0005, "R2 latch", v, 16'h0005);
    check(hirq == 0, "R7 masked still latched", hirq, 0);
    repeat (3) @(negedge clk);
    bus_rd(0, v); check(v == 16'h0005, "R3 held", v, 16'h0005);

    bus_wr(1, 16'h0004);
    bus_rd(1, v); check(v == 16'h0004, "R6 mask rw", v, 16'h0004);
    bus_rd(0, v); check(v == 16'h0005, "R6 pend untouched", v, 16'h0005);
    check(hirq == 1, "R7 asserted", hirq, 1);

    bus_wr(0, 16'h0001);
    bus_rd(0, v); check(v == 16'h0004, "R4 clear one, keep zero bit", v, 16'h0004);
    check(hirq == 1, "R7 still", hirq, 1);
    bus_wr(0, 16'h0004);
    check(hirq == 0, "R4 cleared line drops", hirq, 0);

    pulse(16'h0008);
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = 0; dat_w = 16'h0008; src = 16'h0008;
    @(negedge clk); cyc = 0; stb = 0; we = 0; src = 0;
    bus_rd(0, v); check(v == 16'h0008, "R5 set wins", v, 16'h0008);

    bus_wr(2, 16'hFFFF); bus_wr(3, 16'hFFFF);
    bus_rd(2, v); check(v == 0, "R9 offset2", v, 0);
    bus_rd(3, v); check(v == 0, "R9 offset3", v, 0);
    bus_rd(0, v); check(v == 16'h0008, "R9 pend unchanged", v, 16'h0008);
    bus_rd(1, v); check(v == 16'h0004, "R9 mask unchanged", v, 16'h0004);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      src = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
      cyc = $urandom % 2; stb = $urandom % 2; we = $urandom % 2;
      adr = 2'($urandom); dat_w = 16'($urandom);
    end
    @(negedge clk); cyc = 0; stb = 0; src = 0;
    repeat (2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    check(hirq == 0 && ack == 0, "R1 re-reset", {hirq, ack}, 0);
    rst = 0;
    bus_rd(0, v); check(v == 0, "R1 pending after re-reset", v, 0);
    finish_up();
  end
endmodule